// File: doc/BRIEF.md
# TLB Miss Assist Register Loader

When an address translation misses in the TLB, this block fills a bank of assist registers in one clock. A software miss handler can then write a new TLB entry after changing only the real-page fields. The block takes defaults from a single defaults word: the target array, the page size, the storage attributes and a selector for the tag source. It merges those defaults with the faulting address, the current address space and a chosen process ID.

It also supplies a replacement way from a round-robin counter. The counter value goes into the entry-select field, and the value after the step goes into the next-victim field. The same update records the faulting address and a small exception syndrome. Exception vectoring happens elsewhere. This block only prepares the register images.

The number of ways `WAYS` is a power of two of at least 2, with a default of 4. The process ID width `PID_W` defaults to 8 and must be at most 12. The page offset width `PAGE_SHIFT` defaults to 12 and must be at least 5. Bit positions below assume these defaults. All registers are 32 bits wide.

Top module: `tlb_miss_loader`

## Requirements
- R1: While reset is low, every output register reads zero and the way counter returns to 0.
- R2: On a miss, the outputs take fields from `dflt_i` as follows. Bits [29:28] go to `asn_sel_o[29:28]`. Bits [11:8] go to `asn_desc_o[11:8]`. Bits [4:0] go to `asn_page_o[4:0]`.
- R3: On a miss, `asn_real_o` and `asn_upper_o` become zero. All bits of `asn_srch_o` become zero except [16+PID_W-1:16] and [0].
- R4: On a miss, `asn_desc_o[31]` (entry valid) is set to 1.
- R5: On a miss, `space_i` is written to both `asn_desc_o[12]` and `asn_srch_o[0]`. All other bits of `asn_desc_o` outside the R2, R4, R7 and R8 fields are zero.
- R6: On a miss, `asn_page_o[31:PAGE_SHIFT]` takes `addr_i[31:PAGE_SHIFT]`. The other page bits are zero, except the attribute field from R2.
- R7: When `ext_i` is 0, `dflt_i[17:16]` chooses the tag in `asn_desc_o[16+PID_W-1:16]`. The values are 0 for `pid0_i`, 1 for `pid1_i`, 2 for `pid2_i` and 3 for zero. In this case `asn_srch_o[16+PID_W-1:16]` takes `pid0_i`.
- R8: When `ext_i` is 1, `ext_pid_i` goes into both the tag field and the search process ID field, and the selector is ignored.
- R9: On a miss, `asn_sel_o[16+WAY_W-1:16]` takes the current way count. The counter then steps by one modulo `WAYS`, and `asn_sel_o[WAY_W-1:0]` takes the new count.
- R10: On a miss, `fault_addr_o` takes `addr_i`.
- R11: On a miss, `syndrome_o` is rebuilt with bit 8 set for a store (`acc_i` = 1) and bit 5 set when `ext_i` is 1. All other bits are zero. The access codes are 0 for load, 1 for store and 2 for fetch.
- R12: While `miss_i` is low, no output and no way count changes, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_i | input | 1 | Miss strobe; one update per cycle it is high |
| addr_i | input | 32 | Faulting effective address |
| acc_i | input | 2 | Access type: 0 load, 1 store, 2 fetch |
| ext_i | input | 1 | Access uses an externally supplied process ID |
| ext_pid_i | input | PID_W | Externally supplied process ID |
| pid0_i | input | PID_W | Primary process ID |
| pid1_i | input | PID_W | Second process ID |
| pid2_i | input | PID_W | Third process ID |
| space_i | input | 1 | Current address space |
| dflt_i | input | 32 | Defaults word |
| asn_sel_o | output | 32 | Array select, entry select, next victim |
| asn_desc_o | output | 32 | Valid, tag, space, page size |
| asn_page_o | output | 32 | Effective page number and attributes |
| asn_real_o | output | 32 | Real page assist, cleared on miss |
| asn_srch_o | output | 32 | Search process ID and search space |
| asn_upper_o | output | 32 | Upper address assist, cleared on miss |
| fault_addr_o | output | 32 | Recorded faulting address |
| syndrome_o | output | 32 | Exception syndrome |

## Verification
Every result of a miss comes from registers that load on the rising edge at which `miss_i` is high, so it is due one edge after the strobe. This includes the register images, the fault address, the syndrome and the stepped way count. The bench changes inputs on falling edges and reads outputs on the next falling edge, half a period after the update. For R12, the bench holds the strobe low for several edges while it changes every other input, and compares the outputs with the previous images. It then confirms that the next miss carries on from the way count it left off.

// File: rtl/tma_pkg.sv
package tma_pkg;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    localparam int REG_W          = 32;
    localparam int ARR_LSB        = 28;
    localparam int ARR_W          = 2;
    localparam int SIZE_LSB       = 8;
    localparam int SIZE_W         = 4;
    localparam int ATTR_LSB       = 0;
    localparam int ATTR_W         = 5;
    localparam int TSEL_LSB       = 16;
    localparam int FIELD_LSB      = 16;
    localparam int VALID_BIT      = 31;
    localparam int SPACE_BIT      = 12;
    localparam int SRCH_SPACE_BIT = 0;
    localparam int SYN_STORE_BIT  = 8;
    localparam int SYN_EXT_BIT    = 5;

    typedef struct packed {
        logic [REG_W-1:0] sel;
        logic [REG_W-1:0] desc;
        logic [REG_W-1:0] page;
        logic [REG_W-1:0] real_pg;
        logic [REG_W-1:0] srch;
        logic [REG_W-1:0] upper;
        logic [REG_W-1:0] fault;
        logic [REG_W-1:0] syn;
    } asn_img_t;

endpackage

// File: rtl/tma_way_ctr.sv
module tma_way_ctr #(
    parameter int WAYS  = 4,
    parameter int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    output logic [WAY_W-1:0] cur_o,
    output logic [WAY_W-1:0] nxt_o
);

    localparam logic [WAY_W-1:0] WAY_MASK = WAY_W'(WAYS - 1);

    logic [WAY_W-1:0] cnt_q;

    always_comb begin
        nxt_o = (cnt_q + WAY_W'(1)) & WAY_MASK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (step_i) begin
            cnt_q <= nxt_o;
        end
    end

    assign cur_o = cnt_q;

    // R9
    way_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |=> cnt_q == (($past(cnt_q) + WAY_W'(1)) & WAY_MASK));

    // R12
    way_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> $stable(cnt_q));

endmodule

// File: rtl/tma_tag_pick.sv
module tma_tag_pick #(
    parameter int PID_W = 8
) (
    input  logic             ext_i,
    input  logic [PID_W-1:0] ext_pid_i,
    input  logic [PID_W-1:0] pid0_i,
    input  logic [PID_W-1:0] pid1_i,
    input  logic [PID_W-1:0] pid2_i,
    input  logic [1:0]       sel_i,
    output logic [PID_W-1:0] tag_o,
    output logic [PID_W-1:0] srch_o
);

    always_comb begin
        if (ext_i) begin
            tag_o  = ext_pid_i;
            srch_o = ext_pid_i;
        end else begin
            srch_o = pid0_i;
            unique case (sel_i)
                2'd0:    tag_o = pid0_i;
                2'd1:    tag_o = pid1_i;
                2'd2:    tag_o = pid2_i;
                default: tag_o = '0;
            endcase
        end
    end

endmodule

// File: rtl/tma_image.sv
module tma_image
    import tma_pkg::*;
#(
    parameter int PID_W      = 8,
    parameter int WAY_W      = 2,
    parameter int PAGE_SHIFT = 12
) (
    input  logic [REG_W-1:0] addr_i,
    input  logic [1:0]       acc_i,
    input  logic             ext_i,
    input  logic             space_i,
    input  logic [REG_W-1:0] dflt_i,
    input  logic [PID_W-1:0] tag_i,
    input  logic [PID_W-1:0] srch_pid_i,
    input  logic [WAY_W-1:0] esel_i,
    input  logic [WAY_W-1:0] nv_i,
    output asn_img_t         img_o
);

    localparam int EPN_W = REG_W - PAGE_SHIFT;

    always_comb begin
        img_o = '0;

        img_o.sel[ARR_LSB +: ARR_W]     = dflt_i[ARR_LSB +: ARR_W];
        img_o.sel[FIELD_LSB +: WAY_W]   = esel_i;
        img_o.sel[0 +: WAY_W]           = nv_i;

        img_o.desc[VALID_BIT]           = 1'b1;
        img_o.desc[SPACE_BIT]           = space_i;
        img_o.desc[SIZE_LSB +: SIZE_W]  = dflt_i[SIZE_LSB +: SIZE_W];
        img_o.desc[FIELD_LSB +: PID_W]  = tag_i;

        img_o.page[PAGE_SHIFT +: EPN_W] = addr_i[PAGE_SHIFT +: EPN_W];
        img_o.page[ATTR_LSB +: ATTR_W]  = dflt_i[ATTR_LSB +: ATTR_W];

        img_o.srch[FIELD_LSB +: PID_W]  = srch_pid_i;
        img_o.srch[SRCH_SPACE_BIT]      = space_i;

        img_o.fault                     = addr_i;
        img_o.syn[SYN_STORE_BIT]        = (acc_i == ACC_STORE);
        img_o.syn[SYN_EXT_BIT]          = ext_i;
    end

endmodule

// File: rtl/tlb_miss_loader.sv
module tlb_miss_loader
    import tma_pkg::*;
#(
    parameter int WAYS       = 4,
    parameter int PID_W      = 8,
    parameter int PAGE_SHIFT = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             miss_i,
    input  logic [31:0]      addr_i,
    input  logic [1:0]       acc_i,
    input  logic             ext_i,
    input  logic [PID_W-1:0] ext_pid_i,
    input  logic [PID_W-1:0] pid0_i,
    input  logic [PID_W-1:0] pid1_i,
    input  logic [PID_W-1:0] pid2_i,
    input  logic             space_i,
    input  logic [31:0]      dflt_i,
    output logic [31:0]      asn_sel_o,
    output logic [31:0]      asn_desc_o,
    output logic [31:0]      asn_page_o,
    output logic [31:0]      asn_real_o,
    output logic [31:0]      asn_srch_o,
    output logic [31:0]      asn_upper_o,
    output logic [31:0]      fault_addr_o,
    output logic [31:0]      syndrome_o
);

    localparam int WAY_W = $clog2(WAYS);
    localparam logic [WAY_W-1:0] WAY_MASK = WAY_W'(WAYS - 1);

    logic [WAY_W-1:0] way_cur;
    logic [WAY_W-1:0] way_nxt;
    logic [PID_W-1:0] tag_pick;
    logic [PID_W-1:0] srch_pick;
    asn_img_t         img_d;
    asn_img_t         img_q;

    tma_way_ctr #(
        .WAYS  (WAYS),
        .WAY_W (WAY_W)
    ) u_way (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (miss_i),
        .cur_o  (way_cur),
        .nxt_o  (way_nxt)
    );

    tma_tag_pick #(
        .PID_W (PID_W)
    ) u_tag (
        .ext_i     (ext_i),
        .ext_pid_i (ext_pid_i),
        .pid0_i    (pid0_i),
        .pid1_i    (pid1_i),
        .pid2_i    (pid2_i),
        .sel_i     (dflt_i[TSEL_LSB +: 2]),
        .tag_o     (tag_pick),
        .srch_o    (srch_pick)
    );

    tma_image #(
        .PID_W      (PID_W),
        .WAY_W      (WAY_W),
        .PAGE_SHIFT (PAGE_SHIFT)
    ) u_img (
        .addr_i     (addr_i),
        .acc_i      (acc_i),
        .ext_i      (ext_i),
        .space_i    (space_i),
        .dflt_i     (dflt_i),
        .tag_i      (tag_pick),
        .srch_pid_i (srch_pick),
        .esel_i     (way_cur),
        .nv_i       (way_nxt),
        .img_o      (img_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            img_q <= '0;
        end else if (miss_i) begin
            img_q <= img_d;
        end
    end

    assign asn_sel_o    = img_q.sel;
    assign asn_desc_o   = img_q.desc;
    assign asn_page_o   = img_q.page;
    assign asn_real_o   = img_q.real_pg;
    assign asn_srch_o   = img_q.srch;
    assign asn_upper_o  = img_q.upper;
    assign fault_addr_o = img_q.fault;
    assign syndrome_o   = img_q.syn;

    // R4
    valid_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miss_i |=> asn_desc_o[VALID_BIT]);

    // R3
    cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miss_i |=> (asn_real_o == '0) && (asn_upper_o == '0));

    // R10
    fault_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miss_i |=> fault_addr_o == $past(addr_i));

    // R5
    space_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miss_i |=> asn_desc_o[SPACE_BIT] == asn_srch_o[SRCH_SPACE_BIT]);

    // R9
    victim_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miss_i |=> asn_sel_o[0 +: WAY_W] ==
                   ((asn_sel_o[FIELD_LSB +: WAY_W] + WAY_W'(1)) & WAY_MASK));

    // R11
    store_syn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miss_i |=> syndrome_o[SYN_STORE_BIT] == ($past(acc_i) == ACC_STORE));

    // R12
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !miss_i |=> $stable(img_q));

endmodule

// File: tb/test_tlb_miss_loader.sv
module test_tlb_miss_loader;

    localparam int PID_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             miss_i = 1'b0;
    logic [31:0]      addr_i = '0;
    logic [1:0]       acc_i = '0;
    logic             ext_i = 1'b0;
    logic [PID_W-1:0] ext_pid_i = '0;
    logic [PID_W-1:0] pid0_i = '0;
    logic [PID_W-1:0] pid1_i = '0;
    logic [PID_W-1:0] pid2_i = '0;
    logic             space_i = 1'b0;
    logic [31:0]      dflt_i = '0;
    logic [31:0]      asn_sel_o, asn_desc_o, asn_page_o, asn_real_o;
    logic [31:0]      asn_srch_o, asn_upper_o, fault_addr_o, syndrome_o;

    int n_cmp = 0;
    int n_bad = 0;
    int exp_way = 0;
    logic [31:0] e_sel, e_desc, e_page, e_srch, e_fault, e_syn;

    always #10 clk = ~clk;

    tlb_miss_loader i_tlb_miss_loader (
        .clk          (clk),
        .rst_n        (rst_n),
        .miss_i       (miss_i),
        .addr_i       (addr_i),
        .acc_i        (acc_i),
        .ext_i        (ext_i),
        .ext_pid_i    (ext_pid_i),
        .pid0_i       (pid0_i),
        .pid1_i       (pid1_i),
        .pid2_i       (pid2_i),
        .space_i      (space_i),
        .dflt_i       (dflt_i),
        .asn_sel_o    (asn_sel_o),
        .asn_desc_o   (asn_desc_o),
        .asn_page_o   (asn_page_o),
        .asn_real_o   (asn_real_o),
        .asn_srch_o   (asn_srch_o),
        .asn_upper_o  (asn_upper_o),
        .fault_addr_o (fault_addr_o),
        .syndrome_o   (syndrome_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk({"R2 R9 sel ", tag}, asn_sel_o, e_sel);
        chk({"R4 R5 R7 R8 desc ", tag}, asn_desc_o, e_desc);
        chk({"R2 R6 page ", tag}, asn_page_o, e_page);
        chk({"R3 real ", tag}, asn_real_o, 32'h0);
        chk({"R3 R5 R7 R8 srch ", tag}, asn_srch_o, e_srch);
        chk({"R3 upper ", tag}, asn_upper_o, 32'h0);
        chk({"R10 fault ", tag}, fault_addr_o, e_fault);
        chk({"R11 syndrome ", tag}, syndrome_o, e_syn);
    endtask

    // One miss with the given inputs; expected values from the requirements.
    task automatic do_miss(input string tag, input logic [31:0] a, input logic [1:0] acc,
                           input logic ext, input logic [7:0] ep, input logic sp,
                           input logic [31:0] d);
        logic [7:0] tg;
        @(negedge clk);
        addr_i = a; acc_i = acc; ext_i = ext; ext_pid_i = ep; space_i = sp; dflt_i = d;
        miss_i = 1'b1;
        @(negedge clk);
        miss_i = 1'b0;
        if (ext) tg = ep;
        else begin
            case (d[17:16])
                2'd0:    tg = pid0_i;
                2'd1:    tg = pid1_i;
                2'd2:    tg = pid2_i;
                default: tg = 8'h00;
            endcase
        end
        e_sel = '0;
        e_sel[29:28] = d[29:28];
        e_sel[17:16] = 2'(exp_way);
        exp_way = (exp_way + 1) % 4;
        e_sel[1:0] = 2'(exp_way);
        e_desc = '0;
        e_desc[31] = 1'b1; e_desc[12] = sp; e_desc[11:8] = d[11:8]; e_desc[23:16] = tg;
        e_page = {a[31:12], 7'b0, d[4:0]};
        e_srch = '0;
        e_srch[23:16] = ext ? ep : pid0_i; e_srch[0] = sp;
        e_fault = a;
        e_syn = '0;
        e_syn[8] = (acc == 2'd1); e_syn[5] = ext;
        check_all(tag);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        exp_way = 0;
        chk("R1 sel", asn_sel_o, 32'h0);
        chk("R1 desc", asn_desc_o, 32'h0);
        chk("R1 page", asn_page_o, 32'h0);
        chk("R1 srch", asn_srch_o, 32'h0);
        chk("R1 fault", fault_addr_o, 32'h0);
        chk("R1 syndrome", syndrome_o, 32'h0);
        rst_n = 1'b1;
    endtask

    task automatic t_defaults;
        pid0_i = 8'h11; pid1_i = 8'h22; pid2_i = 8'h33;
        do_miss("defaults A", 32'hDEAD_BEEF, 2'd0, 1'b0, 8'h00, 1'b0, 32'h3000_0F1F);
        do_miss("defaults B", 32'h0000_1FFF, 2'd2, 1'b0, 8'h00, 1'b0, 32'h1000_0A05);
    endtask

    task automatic t_space;
        do_miss("space1", 32'h8000_3000, 2'd0, 1'b0, 8'h00, 1'b1, 32'h2000_0300);
        do_miss("space0", 32'h8000_3000, 2'd0, 1'b0, 8'h00, 1'b0, 32'h2000_0300);
    endtask

    task automatic t_pid_select;
        pid0_i = 8'hA1; pid1_i = 8'hB2; pid2_i = 8'hC3;
        for (int s = 0; s < 4; s++) begin
            do_miss("R7 selector", 32'h4567_8000 + 32'(s), 2'd0, 1'b0, 8'h00, 1'b0,
                    32'h0000_0100 | (32'(s) << 16));
        end
    endtask

    task automatic t_ext;
        do_miss("R8 ext sel1", 32'h1234_5000, 2'd0, 1'b1, 8'h5A, 1'b1, 32'h0001_0200);
        do_miss("R8 ext sel3 store", 32'h1234_6000, 2'd1, 1'b1, 8'hE7, 1'b0, 32'h0003_0200);
    endtask

    task automatic t_ways;
        // R9: five misses in a row cross the wrap from 3 back to 0.
        for (int k = 0; k < 5; k++) begin
            do_miss("R9 wrap", 32'h0001_0000 * 32'(k + 1), 2'd0, 1'b0, 8'h00, 1'b0, 32'h0);
        end
    endtask

    task automatic t_syndrome;
        do_miss("R11 store", 32'hFFFF_F000, 2'd1, 1'b0, 8'h00, 1'b0, 32'h0);
        do_miss("R11 fetch", 32'hFFFF_E000, 2'd2, 1'b0, 8'h00, 1'b0, 32'h0);
        do_miss("R11 load ext", 32'hFFFF_D000, 2'd0, 1'b1, 8'h01, 1'b0, 32'h0);
    endtask

    task automatic t_hold;
        do_miss("R12 prime", 32'h2222_2000, 2'd1, 1'b0, 8'h00, 1'b1, 32'h3002_0B07);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            addr_i = 32'h9999_9000 + 32'(k); acc_i = 2'd2; ext_i = ~ext_i;
            ext_pid_i = 8'hFF; space_i = ~space_i; dflt_i = ~dflt_i;
            pid0_i = pid0_i + 8'd1;
        end
        @(negedge clk);
        check_all("R12 hold");
        pid0_i = 8'h44;
        do_miss("R12 way resume", 32'h3333_3000, 2'd0, 1'b0, 8'h00, 1'b0, 32'h0);
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_defaults();
        t_space();
        t_pid_select();
        t_ext();
        t_ways();
        t_syndrome();
        t_hold();
        do_miss("pre reset", 32'h5555_5000, 2'd0, 1'b0, 8'h00, 1'b0, 32'h0);
        t_reset();
        do_miss("R1 way after reset", 32'h6666_6000, 2'd0, 1'b0, 8'h00, 1'b0, 32'h0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule